// File: doc/BRIEF.md
# UART FIFO Control and Threshold Logic

This block holds the write-only control byte for a UART's pair of FIFOs and turns its settings into the signals that depend on FIFO fill level. Software writes a byte that turns both FIFOs on or off, flushes either one, picks a DMA signalling mode, and chooses a receive trigger level and a transmit-empty threshold. The FIFOs themselves sit outside the block. They report their fill counts on `rx_level` and `tx_level`, and their pointer logic clears when it sees `rx_flush` or `tx_flush`.

From the stored settings and the two counts, the block produces three outputs. `rx_ready_irq` signals that enough receive data is waiting. `tx_low_irq` signals that the transmit FIFO has drained far enough. `rts_n` is the request-to-send line used for automatic flow control. The FIFO depth is a parameter, and every threshold is derived from it. Each flush output is a single registered pulse, so software never has to write a flush bit back to zero.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the enable and DMA-mode outputs are 0, both trigger selections are code 0, and neither flush pulse is active.
- R2: Bit 0 of a written byte sets `fifo_on`. A write that changes its value raises both `rx_flush` and `tx_flush` for exactly the one cycle after the write. A write that leaves it unchanged raises neither.
- R3: Writing 1 to bit 1 raises `rx_flush` for exactly the one cycle after the write, without raising `tx_flush`.
- R4: Writing 1 to bit 2 raises `tx_flush` for exactly the one cycle after the write, without raising `rx_flush`.
- R5: With the FIFOs on, bits 7:6 pick the receive threshold: code 0 is 1, code 1 is DEPTH/4, code 2 is DEPTH/2, and code 3 is DEPTH-2. `rx_ready_irq` is high while `rx_level` is at or above that threshold.
- R6: `rts_n` is high when `auto_flow` is set and `rx_level` is at or above the receive threshold. Otherwise it is low.
- R7: With the FIFOs on and `thre_prog` high, bits 5:4 pick the transmit threshold: code 0 is 0, code 1 is 2, code 2 is DEPTH/4, and code 3 is DEPTH/2. `tx_low_irq` is high while `tx_level` is at or below that threshold.
- R8: A write made while `thre_prog` is low leaves the stored transmit threshold code unchanged.
- R9: While `thre_prog` is low, `tx_low_irq` is high exactly when `tx_level` is 0.
- R10: With the FIFOs off, the receive threshold is 1 and the transmit threshold is 0, whatever codes are stored.
- R11: Bit 3 of a written byte appears on `dma_mode` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte |
| thre_prog | input | 1 | Programmable transmit-empty threshold mode |
| auto_flow | input | 1 | Automatic flow control mode |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill count |
| fifo_on | output | 1 | FIFO enable setting |
| dma_mode | output | 1 | DMA signalling mode setting |
| rx_flush | output | 1 | One-cycle receive FIFO pointer clear |
| tx_flush | output | 1 | One-cycle transmit FIFO pointer clear |
| rx_ready_irq | output | 1 | Receive threshold reached |
| tx_low_irq | output | 1 | Transmit fill at or below threshold |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench builds the block with the default depth of 16. That gives receive thresholds of 1, 4, 8 and 14 and transmit thresholds of 0, 2, 4 and 8, all distinct. With these values every code's boundary can be probed one count below and one count above, inside a 5-bit count. The depth also keeps the quarter, half and near-full points apart, so swapping two decode entries changes an observed output.

// File: rtl/uart_fifo_ctrl_pkg.sv
package uart_fifo_ctrl_pkg;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_RX_CLR = 1;
    localparam int BIT_TX_CLR = 2;
    localparam int BIT_DMA    = 3;
    localparam int TX_LO      = 4;
    localparam int RX_LO      = 6;

    typedef struct packed {
        logic       fifo_on;
        logic       dma_mode;
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       rx_flush;
        logic       tx_flush;
    } fcr_state_t;

    localparam fcr_state_t FCR_RESET = '{default: '0};

endpackage

// File: rtl/uart_fcr_regs.sv
module uart_fcr_regs
    import uart_fifo_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       thre_prog,
    output fcr_state_t state
);

    fcr_state_t state_d, state_q;

    always_comb begin
        state_d          = state_q;
        state_d.rx_flush = 1'b0;
        state_d.tx_flush = 1'b0;
        if (wr_en) begin
            state_d.fifo_on  = wr_data[BIT_ENABLE];
            state_d.dma_mode = wr_data[BIT_DMA];
            state_d.rx_code  = wr_data[RX_LO +: 2];
            if (thre_prog) begin
                state_d.tx_code = wr_data[TX_LO +: 2];
            end
            if (wr_data[BIT_ENABLE] != state_q.fifo_on) begin
                state_d.rx_flush = 1'b1;
                state_d.tx_flush = 1'b1;
            end
            if (wr_data[BIT_RX_CLR]) begin
                state_d.rx_flush = 1'b1;
            end
            if (wr_data[BIT_TX_CLR]) begin
                state_d.tx_flush = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FCR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/uart_fifo_level_map.sv
module uart_fifo_level_map #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_on,
    input  logic [1:0]       rx_code,
    input  logic [1:0]       tx_code,
    output logic [CNT_W-1:0] rx_thr,
    output logic [CNT_W-1:0] tx_thr
);

    localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL_TWO  = CNT_W'(2);
    localparam logic [CNT_W-1:0] LVL_QTR  = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] LVL_NEAR = CNT_W'(DEPTH - 2);

    logic [CNT_W-1:0] rx_sel;
    logic [CNT_W-1:0] tx_sel;

    always_comb begin
        unique case (rx_code)
            2'd0:    rx_sel = LVL_ONE;
            2'd1:    rx_sel = LVL_QTR;
            2'd2:    rx_sel = LVL_HALF;
            default: rx_sel = LVL_NEAR;
        endcase
        unique case (tx_code)
            2'd0:    tx_sel = '0;
            2'd1:    tx_sel = LVL_TWO;
            2'd2:    tx_sel = LVL_QTR;
            default: tx_sel = LVL_HALF;
        endcase
    end

    // A disabled FIFO behaves as one entry deep.
    assign rx_thr = fifo_on ? rx_sel : LVL_ONE;
    assign tx_thr = fifo_on ? tx_sel : '0;

endmodule

// File: rtl/uart_fifo_watch.sv
module uart_fifo_watch #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic             thre_prog,
    input  logic             auto_flow,
    output logic             rx_ready_irq,
    output logic             tx_low_irq,
    output logic             rts_n
);

    logic rx_hit;

    assign rx_hit       = (rx_level >= rx_thr);
    assign rx_ready_irq = rx_hit;
    assign tx_low_irq   = thre_prog ? (tx_level <= tx_thr) : (tx_level == '0);
    assign rts_n        = auto_flow & rx_hit;

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_ctrl_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             thre_prog,
    input  logic             auto_flow,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    output logic             fifo_on,
    output logic             dma_mode,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             rx_ready_irq,
    output logic             tx_low_irq,
    output logic             rts_n
);

    fcr_state_t       cfg;
    logic [CNT_W-1:0] rx_thr;
    logic [CNT_W-1:0] tx_thr;

    uart_fcr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .thre_prog (thre_prog),
        .state     (cfg)
    );

    uart_fifo_level_map #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_map (
        .fifo_on (cfg.fifo_on),
        .rx_code (cfg.rx_code),
        .tx_code (cfg.tx_code),
        .rx_thr  (rx_thr),
        .tx_thr  (tx_thr)
    );

    uart_fifo_watch #(.CNT_W(CNT_W)) u_watch (
        .rx_level     (rx_level),
        .tx_level     (tx_level),
        .rx_thr       (rx_thr),
        .tx_thr       (tx_thr),
        .thre_prog    (thre_prog),
        .auto_flow    (auto_flow),
        .rx_ready_irq (rx_ready_irq),
        .tx_low_irq   (tx_low_irq),
        .rts_n        (rts_n)
    );

    assign fifo_on  = cfg.fifo_on;
    assign dma_mode = cfg.dma_mode;
    assign rx_flush = cfg.rx_flush;
    assign tx_flush = cfg.tx_flush;

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             thre_prog,
    input logic             auto_flow,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             fifo_on,
    input logic             dma_mode,
    input logic             rx_flush,
    input logic             tx_flush,
    input logic             rx_ready_irq,
    input logic             tx_low_irq,
    input logic             rts_n
);

    a_r2_toggle_flushes_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[0] != fifo_on)) |=> (rx_flush && tx_flush));

    a_r3_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!rx_flush && !tx_flush));

    a_r6_rts_low_without_flow: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_flow |-> !rts_n);

    a_r9_tx_empty_only: assert property (@(posedge clk) disable iff (!rst_n)
        !thre_prog |-> (tx_low_irq == (tx_level == '0)));

    a_r10_rx_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (rx_ready_irq == (rx_level != '0)));

    a_r11_dma_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dma_mode == $past(wr_data[3])));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             thre_prog = 1'b0;
    logic             auto_flow = 1'b0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] tx_level = '0;
    logic             fifo_on, dma_mode, rx_flush, tx_flush;
    logic             rx_ready_irq, tx_low_irq, rts_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(DEPTH)) u_uart_fifo_ctrl (.*);

    task automatic check(input int actual, input int expected, input string req);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive a write at a falling edge; returns at the next falling edge,
    // when the registered result of the write is visible.
    task automatic write_fcr(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        check(fifo_on, 0, "R1 fifo_on");
        check(dma_mode, 0, "R1 dma_mode");
        check(rx_flush, 0, "R1 rx_flush");
        check(tx_flush, 0, "R1 tx_flush");
        check(rts_n, 0, "R1 rts_n");
        check(tx_low_irq, 1, "R1 tx_low_irq empty");
    endtask

    task automatic t_enable();
        write_fcr(8'h01);
        check(rx_flush, 1, "R2 rx_flush on toggle");
        check(tx_flush, 1, "R2 tx_flush on toggle");
        check(fifo_on, 1, "R2 fifo_on");
        @(negedge clk);
        check(rx_flush, 0, "R2 rx_flush one cycle");
        check(tx_flush, 0, "R2 tx_flush one cycle");
        write_fcr(8'h01);
        check(rx_flush | tx_flush, 0, "R2 no flush without change");
    endtask

    task automatic t_flushes();
        write_fcr(8'h03);
        check(rx_flush, 1, "R3 rx_flush");
        check(tx_flush, 0, "R3 tx untouched");
        @(negedge clk);
        check(rx_flush, 0, "R3 self clear");
        write_fcr(8'h05);
        check(tx_flush, 1, "R4 tx_flush");
        check(rx_flush, 0, "R4 rx untouched");
        @(negedge clk);
        check(tx_flush, 0, "R4 self clear");
    endtask

    task automatic t_rx_levels();
        int thr[4] = '{1, DEPTH / 4, DEPTH / 2, DEPTH - 2};
        for (int c = 0; c < 4; c++) begin
            write_fcr(8'(c << 6) | 8'h01);
            rx_level = CNT_W'(thr[c] - 1);
            #1 check(rx_ready_irq, 0, "R5 below threshold");
            rx_level = CNT_W'(thr[c]);
            #1 check(rx_ready_irq, 1, "R5 at threshold");
        end
        rx_level = '0;
    endtask

    task automatic t_rts();
        write_fcr(8'h81);
        auto_flow = 1'b1;
        rx_level  = CNT_W'(DEPTH / 2 - 1);
        #1 check(rts_n, 0, "R6 below threshold");
        rx_level  = CNT_W'(DEPTH / 2);
        #1 check(rts_n, 1, "R6 at threshold");
        auto_flow = 1'b0;
        #1 check(rts_n, 0, "R6 flow control off");
        rx_level  = '0;
    endtask

    task automatic t_tx_levels();
        int thr[4] = '{0, 2, DEPTH / 4, DEPTH / 2};
        thre_prog = 1'b1;
        for (int c = 0; c < 4; c++) begin
            write_fcr(8'(c << 4) | 8'h01);
            tx_level = CNT_W'(thr[c]);
            #1 check(tx_low_irq, 1, "R7 at threshold");
            tx_level = CNT_W'(thr[c] + 1);
            #1 check(tx_low_irq, 0, "R7 above threshold");
        end
        tx_level = '0;
    endtask

    task automatic t_tx_code_locked();
        thre_prog = 1'b1;
        write_fcr(8'h21);          // code 2: threshold DEPTH/4
        thre_prog = 1'b0;
        write_fcr(8'h31);          // code 3 attempt, must be dropped
        thre_prog = 1'b1;
        tx_level  = CNT_W'(DEPTH / 4 + 2);
        #1 check(tx_low_irq, 0, "R8 code kept at 2");
        tx_level  = '0;
    endtask

    task automatic t_thre_off();
        thre_prog = 1'b1;
        write_fcr(8'h31);
        thre_prog = 1'b0;
        tx_level  = '0;
        #1 check(tx_low_irq, 1, "R9 empty");
        tx_level  = CNT_W'(1);
        #1 check(tx_low_irq, 0, "R9 one entry");
        tx_level  = '0;
    endtask

    task automatic t_disabled();
        thre_prog = 1'b1;
        write_fcr(8'hF0);
        check(fifo_on, 0, "R10 disabled");
        rx_level = CNT_W'(1);
        #1 check(rx_ready_irq, 1, "R10 rx one entry");
        rx_level = '0;
        #1 check(rx_ready_irq, 0, "R10 rx empty");
        tx_level = CNT_W'(1);
        #1 check(tx_low_irq, 0, "R10 tx one entry");
        tx_level = '0;
        #1 check(tx_low_irq, 1, "R10 tx empty");
        thre_prog = 1'b0;
    endtask

    task automatic t_dma();
        write_fcr(8'h09);
        check(dma_mode, 1, "R11 dma set");
        write_fcr(8'h01);
        check(dma_mode, 0, "R11 dma cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_flushes();
        t_rx_levels();
        t_rts();
        t_tx_levels();
        t_tx_code_locked();
        t_thre_off();
        t_disabled();
        t_dma();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule